// File: doc/BRIEF.md
# Raster Timing Controller with Byte Register Bank

This block produces the sync, blanking and picture-gate signals for a raster display from a set of byte-wide registers. A host writes and reads the registers through a single byte port. Writes happen on the clock edge; reads are combinational. A character divider groups pixel clocks into characters. The horizontal registers are counted in characters and the vertical registers in lines. The block raises a pending flag once per frame when vertical blanking begins, and that flag drives an interrupt line behind an enable bit.

The bank also holds a status byte. This byte samples the monitor identity pins and the resolution sense pins so that software can pick a timing set. One control bit gates the picture without disturbing sync. Another control bit starts or halts the whole generator. The cursor bounds, the transfer-holdoff bounds, the crystal select and the divisor select are stored and read back but have no effect inside this block.

Top module: `vtc_top`

## Requirements
- R1: After reset every writable register reads 0x00. With timing halted, hsync, vsync and csync are low, blank is high, and irq is low.
- R2: Registers occupy offsets 0x10 to 0x1F. The control register is 0x10 and status is 0x11. Cursor bounds are 0x12/0x13. The horizontal registers are 0x14 blank start, 0x15 line length, 0x16 sync start and 0x17 sync end. Composite serration end is 0x18. Vertical blank start is a 16-bit value, high byte 0x19 and low byte 0x1A. Then come 0x1B vertical blank length, 0x1C/0x1D vertical sync start/end, and 0x1E/0x1F transfer holdoff. Every offset except 0x11 reads back what was last written. Offsets 0x00 to 0x0F read 0x00 and ignore writes.
- R3: Status reads as {pending, sense[2:0], id[3:0]} in bits 7, 6:4 and 3:0. The sense and id fields follow the mon_sense and mon_id pins through one register stage. Writes leave bits 6:0 unchanged.
- R4: One character is 8 clocks. A line is (0x15) characters. Horizontal blank covers characters at or above (0x14). hsync is high for characters c with (0x16) <= c < (0x17).
- R5: A frame is vbs + (0x1B) lines, where vbs is the 16-bit vertical blank start. Vertical blank covers lines at or above vbs. vsync is high on line l when vbs+(0x1C) <= l < vbs+(0x1D). The vsync period therefore equals 8 × line length × frame lines clocks.
- R6: Outside vsync lines, csync equals hsync. On vsync lines, csync is high for characters at or above (0x18).
- R7: video_on is high only when timing is on, control bit 6 is set, and blank is low. Clearing bit 6 leaves hsync, vsync and csync unchanged.
- R8: When control bit 5 is clear, the counters are held at zero, hsync, vsync, csync and video_on are low, and blank is high.
- R9: The pending flag (status bit 7) sets on the clock where the line counter enters vbs, and only while timing runs. Writing 0x11 with bit 7 set clears the flag. A set on the same edge wins over the clear.
- R10: irq is the pending flag gated by control bit 7. Control bits 4:0 are stored only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| mon_id | input | 4 | Monitor identity pins |
| mon_sense | input | 3 | Monitor resolution sense pins |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| csync | output | 1 | Composite sync, active high |
| blank | output | 1 | Blanking, active high |
| video_on | output | 1 | Picture gate |
| irq | output | 1 | Interrupt request |

## Verification
The generator is exercised with three timing sets. The sets differ in line length, frame height, sync placement and serration point. One of them has vertical sync starting right at blank start, and one has the picture gate off. Over one measured frame the bench counts the vsync period and the high clocks of hsync, vsync, csync, blank and video_on. Each count depends on a different register, so an error in one field shows up in its own count. The picture-gate-off set shows that sync keeps running while video is dark. Directed tests cover pin sampling into status, write masking of status and of the low address half, and the set and clear of the pending flag with timing running and halted.

// File: rtl/vtc_pkg.sv
package vtc_pkg;

  typedef enum logic [3:0] {
    RG_CTRL = 4'h0,
    RG_STAT = 4'h1,
    RG_CURS = 4'h2,
    RG_CURE = 4'h3,
    RG_HBS  = 4'h4,
    RG_HLEN = 4'h5,
    RG_HSS  = 4'h6,
    RG_HSE  = 4'h7,
    RG_CSE  = 4'h8,
    RG_VBSH = 4'h9,
    RG_VBSL = 4'hA,
    RG_VBL  = 4'hB,
    RG_VSS  = 4'hC,
    RG_VSE  = 4'hD,
    RG_XHS  = 4'hE,
    RG_XHE  = 4'hF
  } reg_idx_e;

  localparam int CB_IEN = 7;
  localparam int CB_VEN = 6;
  localparam int CB_TEN = 5;
  localparam int SB_PEND = 7;

  // half-open window test: lo <= v < hi
  function automatic logic in_span(logic [15:0] v, logic [15:0] lo, logic [15:0] hi);
    return (v >= lo) && (v < hi);
  endfunction

  // total lines in a frame: visible lines plus blank length
  function automatic logic [16:0] frame_lines(logic [15:0] vbs, logic [7:0] vbl);
    return {1'b0, vbs} + 17'(vbl);
  endfunction

endpackage

// File: rtl/vtc_regs.sv
module vtc_regs
  import vtc_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic [3:0]    mon_id,
  input  logic [2:0]    mon_sense,
  input  logic          vbl_evt,
  output logic          ien,
  output logic          ven,
  output logic          ten,
  output logic [7:0]    hbs,
  output logic [7:0]    hlen,
  output logic [7:0]    hss,
  output logic [7:0]    hse,
  output logic [7:0]    cse,
  output logic [15:0]   vbs,
  output logic [7:0]    vbl,
  output logic [7:0]    vss,
  output logic [7:0]    vse,
  output logic          pend,
  output logic          irq
);
  localparam int IDX_W = AW - 1;
  localparam int NREG  = 1 << IDX_W;

  logic [7:0]       bank [NREG];
  logic [IDX_W-1:0] idx;
  logic             hi_half;
  logic [3:0]       id_q;
  logic [2:0]       sense_q;
  logic             stat_sel;
  logic             pend_clr;
  logic [7:0]       status_byte;

  assign idx      = addr[IDX_W-1:0];
  assign hi_half  = addr[AW-1];
  assign stat_sel = hi_half && (idx == IDX_W'(RG_STAT));
  assign pend_clr = wr_en && stat_sel && wdata[SB_PEND];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else if (wr_en && hi_half && !stat_sel) begin
      bank[idx] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q    <= '0;
      sense_q <= '0;
    end else begin
      id_q    <= mon_id;
      sense_q <= mon_sense;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend <= 1'b0;
    else if (vbl_evt)  pend <= 1'b1;
    else if (pend_clr) pend <= 1'b0;
  end

  assign status_byte = {pend, sense_q, id_q};

  always_comb begin
    if (!hi_half)      rdata = '0;
    else if (stat_sel) rdata = status_byte;
    else               rdata = bank[idx];
  end

  assign ien  = bank[RG_CTRL][CB_IEN];
  assign ven  = bank[RG_CTRL][CB_VEN];
  assign ten  = bank[RG_CTRL][CB_TEN];
  assign hbs  = bank[RG_HBS];
  assign hlen = bank[RG_HLEN];
  assign hss  = bank[RG_HSS];
  assign hse  = bank[RG_HSE];
  assign cse  = bank[RG_CSE];
  assign vbs  = {bank[RG_VBSH], bank[RG_VBSL]};
  assign vbl  = bank[RG_VBL];
  assign vss  = bank[RG_VSS];
  assign vse  = bank[RG_VSE];
  assign irq  = pend && ien;

endmodule

// File: rtl/vtc_counters.sv
module vtc_counters
  import vtc_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int HW     = 8,
  parameter int VW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ten,
  input  logic [HW-1:0] hlen,
  input  logic [VW-1:0] vbs,
  input  logic [7:0]    vbl,
  output logic [HW-1:0] hc,
  output logic [VW-1:0] vc,
  output logic          tick,
  output logic          vbl_evt
);
  localparam int DIV_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;

  logic [DIV_W-1:0] div;
  logic             line_last;
  logic             frame_last;
  logic [VW-1:0]    vc_next;

  assign tick       = ten && (div == DIV_W'(CHAR_W - 1));
  assign line_last  = ({1'b0, hc} + (HW+1)'(1)) >= {1'b0, hlen};
  assign frame_last = ({1'b0, vc} + (VW+1)'(1)) >= frame_lines(vbs, vbl);
  assign vc_next    = frame_last ? '0 : vc + VW'(1);
  assign vbl_evt    = tick && line_last && (vc_next == vbs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= '0;
      hc  <= '0;
      vc  <= '0;
    end else if (!ten) begin
      div <= '0;
      hc  <= '0;
      vc  <= '0;
    end else begin
      div <= tick ? '0 : div + DIV_W'(1);
      if (tick) begin
        if (line_last) begin
          hc <= '0;
          vc <= vc_next;
        end else begin
          hc <= hc + HW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/vtc_syncgen.sv
module vtc_syncgen
  import vtc_pkg::*;
#(
  parameter int HW = 8,
  parameter int VW = 16
) (
  input  logic          ten,
  input  logic          ven,
  input  logic [HW-1:0] hc,
  input  logic [VW-1:0] vc,
  input  logic [7:0]    hbs,
  input  logic [7:0]    hss,
  input  logic [7:0]    hse,
  input  logic [7:0]    cse,
  input  logic [VW-1:0] vbs,
  input  logic [7:0]    vss,
  input  logic [7:0]    vse,
  output logic          hsync,
  output logic          vsync,
  output logic          csync,
  output logic          blank,
  output logic          video_on
);
  logic          h_blank;
  logic          v_blank;
  logic          h_win;
  logic          v_win;
  logic [VW-1:0] v_rel;

  assign v_blank = vc >= vbs;
  assign h_blank = 16'(hc) >= 16'(hbs);
  assign v_rel   = vc - vbs;
  assign h_win   = in_span(16'(hc), 16'(hss), 16'(hse));
  assign v_win   = v_blank && in_span(16'(v_rel), 16'(vss), 16'(vse));

  assign hsync    = ten && h_win;
  assign vsync    = ten && v_win;
  assign csync    = ten && (v_win ? (16'(hc) >= 16'(cse)) : h_win);
  assign blank    = !ten || h_blank || v_blank;
  assign video_on = ten && ven && !h_blank && !v_blank;

endmodule

// File: rtl/vtc_top.sv
module vtc_top
  import vtc_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int AW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [3:0]    mon_id,
  input  logic [2:0]    mon_sense,
  output logic          hsync,
  output logic          vsync,
  output logic          csync,
  output logic          blank,
  output logic          video_on,
  output logic          irq
);
  localparam int HW = 8;
  localparam int VW = 16;

  logic          ien, ven, ten, pend;
  logic          tick, vbl_evt;
  logic [7:0]    hbs, hlen, hss, hse, cse, vbl, vss, vse;
  logic [VW-1:0] vbs;
  logic [HW-1:0] hc;
  logic [VW-1:0] vc;

  vtc_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .mon_id(mon_id),
    .mon_sense(mon_sense), .vbl_evt(vbl_evt), .ien(ien), .ven(ven),
    .ten(ten), .hbs(hbs), .hlen(hlen), .hss(hss), .hse(hse), .cse(cse),
    .vbs(vbs), .vbl(vbl), .vss(vss), .vse(vse), .pend(pend), .irq(irq)
  );

  vtc_counters #(.CHAR_W(CHAR_W), .HW(HW), .VW(VW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ten(ten), .hlen(hlen), .vbs(vbs),
    .vbl(vbl), .hc(hc), .vc(vc), .tick(tick), .vbl_evt(vbl_evt)
  );

  vtc_syncgen #(.HW(HW), .VW(VW)) u_sync (
    .ten(ten), .ven(ven), .hc(hc), .vc(vc), .hbs(hbs), .hss(hss),
    .hse(hse), .cse(cse), .vbs(vbs), .vss(vss), .vse(vse),
    .hsync(hsync), .vsync(vsync), .csync(csync), .blank(blank),
    .video_on(video_on)
  );

endmodule

// File: rtl/vtc_checker.sv
module vtc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic [4:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       hsync,
  input logic       vsync,
  input logic       blank,
  input logic       video_on,
  input logic       irq,
  input logic       ten,
  input logic       ien,
  input logic       pend,
  input logic       tick,
  input logic       vbl_evt
);
  // R8: halted generator emits no sync and keeps blank
  a_r8_halted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ten |-> (!hsync && !vsync && blank && !video_on));

  // R5: vertical sync lies inside vertical blank
  a_r5_vsync_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> blank);

  // R7: picture gate never overlaps blank
  a_r7_gate_not_blank: assert property (@(posedge clk) disable iff (!rst_n)
    video_on |-> !blank);

  // R10: no interrupt while its enable is clear
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);

  // R9: pending only rises after a vertical-blank entry event
  a_r9_set_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(vbl_evt));

  // R9: write-one-to-clear takes effect unless a set collides
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 5'h11 && bus_wdata[7] && !vbl_evt) |=> !pend);

  // R4: while running, hsync moves only on character boundaries
  a_r4_hsync_on_char: assert property (@(posedge clk) disable iff (!rst_n)
    (ten && $past(ten) && (hsync != $past(hsync))) |-> $past(tick));

endmodule

bind vtc_top vtc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .hsync(hsync), .vsync(vsync), .blank(blank),
  .video_on(video_on), .irq(irq), .ten(ten), .ien(ien), .pend(pend),
  .tick(tick), .vbl_evt(vbl_evt)
);

// File: tb/sim_vtc_top.sv
`timescale 1ns/1ps
module sim_vtc_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] mon_id = 4'h1;
  logic [2:0] mon_sense = 3'h4;
  logic hsync, vsync, csync, blank, video_on, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vtc_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mon_id(mon_id),
    .mon_sense(mon_sense), .hsync(hsync), .vsync(vsync), .csync(csync),
    .blank(blank), .video_on(video_on), .irq(irq)
  );

  // columns: hbs hlen hss hse cse vbs vbl vss vse ven
  localparam int TBL [3][10] = '{
    '{4, 6, 4, 5, 2, 4, 3, 1, 2, 1},
    '{2, 5, 3, 5, 1, 3, 4, 0, 2, 0},
    '{5, 8, 6, 8, 4, 6, 2, 0, 1, 1}
  };
  localparam int EXP_PERIOD [3] = '{336, 280, 512};
  localparam int EXP_VIDEO  [3] = '{128, 0, 240};

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5'h10, d); chk("R1 ctrl", d, 0);
    rd(5'h14, d); chk("R1 hbs", d, 0);
    chk("R1 outputs {hs,vs,cs,blank,irq}", {hsync, vsync, csync, blank, irq}, 5'b00010);

    // R3 status from pins, writes masked
    rd(5'h11, d); chk("R3 status color/76", d, 8'h41);
    wr(5'h11, 8'h7F);
    rd(5'h11, d); chk("R3 status write ignored", d, 8'h41);
    mon_id = 4'h3; mon_sense = 3'h6;
    repeat (2) @(negedge clk);
    rd(5'h11, d); chk("R3 status follows pins", d, 8'h63);

    // R2 readback and low half
    wr(5'h19, 8'hA5); rd(5'h19, d); chk("R2 vbs high", d, 8'hA5);
    wr(5'h1E, 8'h3C); rd(5'h1E, d); chk("R2 holdoff start", d, 8'h3C);
    wr(5'h10, 8'h1F); rd(5'h10, d); chk("R2 R10 ctrl low bits stored", d, 8'h1F);
    wr(5'h05, 8'h77); rd(5'h05, d); chk("R2 low half reads zero", d, 0);

    // R4 R5 R6 R7 table of timing sets
    for (int v = 0; v < 3; v++) begin
      int hbs_v, hl, hs0, hs1, cs0, vb, vl, vs0, vs1, lines, vsl;
      int per, c_hs, c_vs, c_cs, c_bl, c_vid, guard;
      logic prev;
      hbs_v = TBL[v][0]; hl = TBL[v][1]; hs0 = TBL[v][2]; hs1 = TBL[v][3];
      cs0 = TBL[v][4]; vb = TBL[v][5]; vl = TBL[v][6]; vs0 = TBL[v][7];
      vs1 = TBL[v][8];
      lines = vb + vl; vsl = vs1 - vs0;
      wr(5'h10, 8'h00);
      wr(5'h14, 8'(hbs_v)); wr(5'h15, 8'(hl)); wr(5'h16, 8'(hs0));
      wr(5'h17, 8'(hs1)); wr(5'h18, 8'(cs0)); wr(5'h19, 8'h00);
      wr(5'h1A, 8'(vb)); wr(5'h1B, 8'(vl)); wr(5'h1C, 8'(vs0));
      wr(5'h1D, 8'(vs1));
      wr(5'h10, (TBL[v][9] != 0) ? 8'h60 : 8'h20);
      @(negedge clk); prev = vsync;
      @(negedge clk);
      guard = 0;
      while (!(vsync && !prev) && guard < 5000) begin
        prev = vsync; @(negedge clk); guard++;
      end
      per = 0; c_hs = 0; c_vs = 0; c_cs = 0; c_bl = 0; c_vid = 0;
      do begin
        per++;
        c_hs += int'(hsync); c_vs += int'(vsync); c_cs += int'(csync);
        c_bl += int'(blank); c_vid += int'(video_on);
        prev = vsync;
        @(negedge clk);
      end while (!(vsync && !prev) && per < 5000);
      chk("R5 frame period", per, EXP_PERIOD[v]);
      chk("R4 hsync clocks", c_hs, 8 * (hs1 - hs0) * lines);
      chk("R5 vsync clocks", c_vs, 8 * hl * vsl);
      chk("R4 R5 blank clocks", c_bl, 8 * (hl * lines - hbs_v * vb));
      chk("R6 csync clocks", c_cs, 8 * ((hs1 - hs0) * (lines - vsl) + (hl - cs0) * vsl));
      chk("R7 video clocks", c_vid, EXP_VIDEO[v]);
    end

    // R9 R10 pending and interrupt
    rd(5'h11, d); chk("R9 pending set by frames", int'(d[7]), 1);
    chk("R10 irq masked", int'(irq), 0);
    wr(5'h10, 8'h80);
    @(negedge clk); chk("R10 irq with enable", int'(irq), 1);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 64; i++) begin
        @(negedge clk);
        if (hsync || vsync || csync || !blank || video_on) bad++;
      end
      chk("R8 halted outputs", bad, 0);
    end
    wr(5'h11, 8'h80);
    rd(5'h11, d); chk("R9 cleared by write one", int'(d[7]), 0);
    chk("R10 irq after clear", int'(irq), 0);
    repeat (700) @(negedge clk);
    rd(5'h11, d); chk("R9 no set while halted", int'(d[7]), 0);

    finish_run();
  end
endmodule